// File: doc/BRIEF.md
# Parallel Sensor Line Grabber

This block takes pixel bytes from an image sensor that drives a parallel data bus, a pixel strobe and two blanking flags. None of these inputs shares a clock with the system. The block stores the bytes of one chosen image line in an on-chip line buffer. On every falling edge of the raw strobe, the data bus and the two flags are caught in input registers. The strobe itself passes through a two-flop synchroniser, and its falling edge is detected in the system clock domain. At that point the held byte is written to the buffer, as long as both flags showed the sensor outside blanking when the strobe fell.

Software, or a neighbouring block, arms a capture with a one-cycle `arm` pulse. The grabber then waits for a frame start, which is a rising edge of `vact`. It counts line starts, which are rising edges of `hact`, and fills the buffer from address 0 during line number `LINE_SEL`, counting from 0. It raises `done` for one cycle in any of three cases: the buffer holds `PIX_MAX` bytes, the chosen line ends, or the frame ends. `byte_cnt` then reports how many bytes were written. The buffer is read through a synchronous port. The system clock must run at least four times as fast as the pixel strobe.

Top module: `cam_line_grab`

## Requirements
- R1: After reset, `done` is 0, `byte_cnt` is 0 and `overrun` is 0.
- R2: Without an `arm` pulse, a complete frame produces no `done` pulse and leaves `byte_cnt` unchanged.
- R3: After arming, only the bytes of line `LINE_SEL` are stored. Line 0 is the first line that begins with a rising edge of `hact` after a rising edge of `vact`.
- R4: A byte is accepted only on a strobe falling edge at which both `vact` and `hact` are 1. Falling edges while either flag is 0 store nothing. Accepted bytes go to consecutive addresses starting at 0.
- R5: When the chosen line carries at least `PIX_MAX` bytes, exactly `PIX_MAX` are stored. `done` is then high for exactly one cycle, and `byte_cnt` equals `PIX_MAX` and holds until the next `arm`.
- R6: When the chosen line ends, on a falling edge of `hact`, after fewer than `PIX_MAX` bytes, `done` pulses once and `byte_cnt` equals the line length.
- R7: When the frame ends, on a falling edge of `vact`, before the chosen line has begun, `done` pulses once and `byte_cnt` is 0.
- R8: Suppose two raw strobe falling edges arrive before the first of them has been written during capture. Then `overrun` rises and stays 1 until the next `arm`, which clears it. The burst counts as one stored byte.
- R9: `rd_data` equals the buffer word at `rd_addr` one clock after `rd_addr` is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous for the strobe-side registers |
| arm | input | 1 | One-cycle pulse that starts a new capture and clears `byte_cnt` and `overrun` |
| pix_d | input | DW | Sensor data bus, valid at the strobe's falling edge |
| pix_strb | input | 1 | Sensor pixel strobe, asynchronous |
| vact | input | 1 | High while the sensor is outside vertical blanking |
| hact | input | 1 | High while the sensor is outside horizontal blanking |
| done | output | 1 | One-cycle pulse at the end of a capture |
| byte_cnt | output | $clog2(PIX_MAX+1) | Bytes written in the current or last capture |
| overrun | output | 1 | Sticky flag: strobe edges came faster than they could be written |
| rd_addr | input | $clog2(PIX_MAX) | Line buffer read address |
| rd_data | output | DW | Line buffer read data, registered |

## Verification
The overrun case is the hardest to produce from the ports. It needs two falling edges of the raw strobe that land between two rising edges of the system clock. The synchroniser then sees only one fall, while the edge counter on the strobe side advances by two. The bench produces this by timing a 1 ns high glitch on the strobe relative to the system clock, placed in the middle of the chosen line. It then checks that the flag is set, that the stored count grows by one and not two, and that the next `arm` clears the flag.

// File: rtl/cam_line_grab.sv
module cam_line_grab #(
  parameter int DW       = 8,
  parameter int PIX_MAX  = 32,
  parameter int LINE_SEL = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         arm,
  input  logic [DW-1:0]                pix_d,
  input  logic                         pix_strb,
  input  logic                         vact,
  input  logic                         hact,
  output logic                         done,
  output logic [$clog2(PIX_MAX+1)-1:0] byte_cnt,
  output logic                         overrun,
  input  logic [$clog2(PIX_MAX)-1:0]   rd_addr,
  output logic [DW-1:0]                rd_data
);
  localparam int AW = $clog2(PIX_MAX);
  localparam int CW = $clog2(PIX_MAX+1);
  localparam int LW = $clog2(LINE_SEL+3);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;

  // strobe domain: data, qualifier and gray-coded edge count
  logic [DW-1:0] dlat;
  logic          qlat;
  logic [1:0]    gcnt;

  always_ff @(negedge pix_strb or negedge rst_n)
    if (!rst_n) begin
      dlat <= '0;
      qlat <= 1'b0;
      gcnt <= 2'b00;
    end else begin
      dlat <= pix_d;
      qlat <= vact & hact;
      gcnt <= {gcnt[0], ~gcnt[1]};
    end

  // system domain
  logic [2:0] ss, vs, hs;
  logic [1:0] gs1, gs2, pc;
  logic [LW-1:0] hcnt;
  logic [CW-1:0] cnt;
  st_t st;
  logic [DW-1:0] mem [PIX_MAX];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ss  <= '0;
      vs  <= '0;
      hs  <= '0;
      gs1 <= '0;
      gs2 <= '0;
    end else begin
      ss  <= {ss[1:0], pix_strb};
      vs  <= {vs[1:0], vact};
      hs  <= {hs[1:0], hact};
      gs1 <= gcnt;
      gs2 <= gs1;
    end

  wire       fall  = ss[2] & ~ss[1];
  wire       vrise = vs[1] & ~vs[2];
  wire       vfall = vs[2] & ~vs[1];
  wire       hrise = hs[1] & ~hs[2];
  wire       hfall = hs[2] & ~hs[1];
  wire [1:0] gb    = {gs2[1], gs2[1] ^ gs2[0]};
  wire [1:0] gap   = gb - pc;
  wire       sel   = (hcnt == LW'(LINE_SEL + 1));
  wire       wr_en = (st == S_RUN) && sel && fall && qlat;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      overrun <= 1'b0;
      hcnt    <= '0;
      pc      <= '0;
    end else begin
      done <= 1'b0;
      if (fall) pc <= gb;
      if (arm) begin
        st      <= S_WAIT;
        cnt     <= '0;
        overrun <= 1'b0;
        hcnt    <= '0;
      end else begin
        case (st)
          S_WAIT: if (vrise) begin
            st   <= S_RUN;
            hcnt <= '0;
          end
          S_RUN: begin
            if (fall && gap != 2'd1) overrun <= 1'b1;
            if (hrise && hcnt <= LW'(LINE_SEL)) hcnt <= hcnt + 1'b1;
            if (wr_en) begin
              cnt <= cnt + 1'b1;
              if (cnt == CW'(PIX_MAX - 1)) begin
                done <= 1'b1;
                st   <= S_IDLE;
              end
            end else if ((sel && hfall) || vfall) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk) begin
    if (wr_en) mem[cnt[AW-1:0]] <= dlat;
    rd_data <= mem[rd_addr];
  end

  assign byte_cnt = cnt;
endmodule

// File: rtl/cam_line_grab_chk.sv
module cam_line_grab_chk #(
  parameter int PIX_MAX = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         arm,
  input logic                         done,
  input logic                         overrun,
  input logic [$clog2(PIX_MAX+1)-1:0] byte_cnt
);
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= ($clog2(PIX_MAX+1))'(PIX_MAX));

  a_r8_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !arm) |=> overrun);

  a_r4_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (byte_cnt == $past(byte_cnt) || byte_cnt == $past(byte_cnt) + 1'b1));

  a_r5_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> $stable(byte_cnt));
endmodule

bind cam_line_grab cam_line_grab_chk #(.PIX_MAX(PIX_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .done(done),
  .overrun(overrun), .byte_cnt(byte_cnt)
);

// File: tb/cam_line_grab_tb.sv
module cam_line_grab_tb_top;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int PM = 6;
  localparam int LS = 2;
  localparam int AW = $clog2(PM);
  localparam int CW = $clog2(PM+1);

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic [DW-1:0] pix_d = '0;
  logic pix_strb = 1'b0, vact = 1'b0, hact = 1'b0;
  logic done, overrun;
  logic [CW-1:0] byte_cnt;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  int checks = 0, errors = 0, done_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  cam_line_grab #(.DW(DW), .PIX_MAX(PM), .LINE_SEL(LS)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .pix_d(pix_d), .pix_strb(pix_strb),
    .vact(vact), .hact(hact), .done(done), .byte_cnt(byte_cnt),
    .overrun(overrun), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(negedge clk) if (done) done_cnt++;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pv(int f, int l, int p);
    return 8'((f * 29 + l * 16 + p * 3 + 1) & 8'hff);
  endfunction

  task automatic strb(input logic [7:0] d, input logic v, input logic h);
    @(negedge clk);
    #2 pix_strb = 1'b1; pix_d = d; vact = v; hact = h;
    #25 pix_strb = 1'b0;
    #20;
  endtask

  task automatic dbl(input logic [7:0] d1, input logic [7:0] d2);
    @(negedge clk);
    #2 pix_strb = 1'b1; pix_d = d1; vact = 1'b1; hact = 1'b1;
    #29 pix_strb = 1'b0;
    #1 pix_strb = 1'b1; pix_d = d2;
    #1 pix_strb = 1'b0;
    #14;
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic frame(input int f, input int nl, input int len, input int dbl_at);
    for (int i = 0; i < 3; i++) strb(8'hEE, 1'b0, 1'b0);
    strb(8'hE0, 1'b1, 1'b0);
    for (int l = 0; l < nl; l++) begin
      strb(8'hB0, 1'b1, 1'b0);
      strb(8'hB1, 1'b1, 1'b0);
      for (int p = 0; p < len; p++)
        if (p == dbl_at) dbl(8'h5A, pv(f, l, p));
        else strb(pv(f, l, p), 1'b1, 1'b1);
      strb(8'hB2, 1'b1, 1'b0);
    end
    strb(8'hEF, 1'b0, 1'b0);
    strb(8'hEF, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
    rd_addr = AW'(a);
    @(negedge clk);
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 0, "R1 done", done, 0);
    chk(byte_cnt == 0, "R1 byte_cnt", byte_cnt, 0);
    chk(overrun == 0, "R1 overrun", overrun, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    frame(0, 4, 4, -1);
    chk(done_cnt == 0, "R2 no done without arm", done_cnt, 0);
    chk(byte_cnt == 0, "R2 byte_cnt", byte_cnt, 0);

    for (int len = 1; len <= PM + 3; len++) begin
      int exp_n;
      exp_n = (len < PM) ? len : PM;
      do_arm();
      done_cnt = 0;
      frame(len, 4, len, -1);
      chk(done_cnt == 1, (len >= PM) ? "R5 one done pulse" : "R6 one done pulse", done_cnt, 1);
      chk(byte_cnt == CW'(exp_n), (len >= PM) ? "R5 byte_cnt" : "R6 byte_cnt", byte_cnt, exp_n);
      chk(overrun == 0, "R8 no overrun at nominal rate", overrun, 0);
      for (int a = 0; a < exp_n; a++)
        rd_chk(a, pv(len, LS, a), "R3 R4 R9 buffer word");
    end

    do_arm();
    done_cnt = 0;
    frame(20, LS, 3, -1);
    chk(done_cnt == 1, "R7 done at frame end", done_cnt, 1);
    chk(byte_cnt == 0, "R7 byte_cnt", byte_cnt, 0);

    do_arm();
    done_cnt = 0;
    frame(30, 4, 4, 2);
    chk(overrun == 1, "R8 overrun set", overrun, 1);
    chk(byte_cnt == 4, "R8 burst counts once", byte_cnt, 4);
    chk(done_cnt == 1, "R6 done after overrun line", done_cnt, 1);
    rd_chk(1, pv(30, LS, 1), "R8 word before burst");
    rd_chk(2, pv(30, LS, 2), "R8 burst keeps newest byte");
    rd_chk(3, pv(30, LS, 3), "R8 word after burst");
    repeat (5) @(negedge clk);
    chk(overrun == 1, "R8 overrun sticky", overrun, 1);
    do_arm();
    @(negedge clk);
    chk(overrun == 0, "R8 arm clears overrun", overrun, 0);
    chk(byte_cnt == 0, "R5 arm clears byte_cnt", byte_cnt, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule